// File: doc/BRIEF.md
# Switchable Memory Section Decoder

This block decides, once per clock, whether a memory card answers the current bus address. It looks only at address bits A15..A11. Eight coarse enables each open one 8K section of the 64K space. The topmost 8K section can be handed to four fine 2K pieces instead. Each fine piece carries a two-bit mode that ties it to the bank state in its own way. Bank gating is set separately for the lower and the upper 32K half.

The card holds three quarters of the space by default (parameter `CARD_QUARTERS`). A remap input moves that window from the low three quadrants to the high three. The select output and two active-low half enables are registered, so each one reflects the inputs sampled at the previous clock edge.

Top module: `memwin_decode`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `sel_o`=0, `lo_en_n_o`=1 and `hi_en_n_o`=1.
- R2: Every output is registered: its value after a rising edge depends only on the inputs sampled at that edge.
- R3: Outside fine mode, coarse section k (address `addr_hi_i[4:2]`==k, k=0..7, i.e. 8K sections from 0000H up to E000H) is a candidate only when `sect_sw_i[k]`=1 and its half is live under the bank gating.
- R4: Fine mode is in force whenever `fine_sw_i` is nonzero. In fine mode the section E000H–FFFFH follows the fine pieces and ignores `sect_sw_i[7]`, even when that bit is 1.
- R5: In fine mode, piece p = `addr_hi_i[1:0]` (E000H, E800H, F000H, F800H for p=0..3) uses code `fine_sw_i[2p+1:2p]`. Code 00 never answers, 01 answers only while `occluded_i`=1, 10 answers only while `occluded_i`=0, and 11 always answers.
- R6: Fine pieces are not gated by `bank_mode_i`: the same code gives the same answer under all four bank modes.
- R7: `bank_mode_i` encodes 00 = both halves always on, 01 = both halves switchable, 10 = lower half switchable and upper always on, 11 = upper half switchable and lower always on. A switchable half is dead while `occluded_i`=1.
- R8: `lo_en_n_o` (0000H–7FFFH) and `hi_en_n_o` (8000H–FFFFH) are 0 exactly when their half is live under R7. They do not depend on the address.
- R9: With `CARD_QUARTERS`=3, `remap_i`=0 limits answers to quadrants 0..2 (0000H–BFFFH), and `remap_i`=1 limits them to quadrants 1..3 (4000H–FFFFH). The quadrant is `addr_hi_i[4:3]`.
- R10: `sel_o` is 1 only for a cycle with `mem_cycle_i`=1 and `refresh_i`=0 that also meets R3–R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_hi_i | input | 5 | Address bits A15..A11 |
| mem_cycle_i | input | 1 | Bus cycle is a memory read or write |
| refresh_i | input | 1 | Bus cycle is a refresh cycle |
| occluded_i | input | 1 | 1 while this card's bank is switched off |
| sect_sw_i | input | 8 | Coarse 8K section enables, bit k = section k |
| fine_sw_i | input | 8 | Four 2-bit fine piece codes for the top 8K |
| bank_mode_i | input | 2 | Per-half bank gating mode |
| remap_i | input | 1 | Move the card window to the high quadrants |
| sel_o | output | 1 | Card answers this cycle (registered) |
| lo_en_n_o | output | 1 | Lower half may respond, active low (registered) |
| hi_en_n_o | output | 1 | Upper half may respond, active low (registered) |

## Verification
The bench targets the top section with `sect_sw_i[7]` and the fine codes set against each other. A design that let the coarse bit win would map memory over the hole at E800H. Each fine code is tried under both occlusion states and all bank modes; a decoder that gated fine pieces by the half's bank mode would drop always-on pieces while the bank is off. Remap is checked at 0000H and at C000H–FFFFH, where the wrong choice of quadrant gives a card that answers at the wrong end. Refresh cycles and cycles that are not memory cycles are mixed into random traffic, so any leak of select shows up there.

// File: rtl/memwin_pkg.sv
// Shared types for the memory window decoder.
// Assumes a 64K space cut into 8K sections and 2K fine pieces.
package memwin_pkg;

    // Per-half bank gating choice.
    typedef enum logic [1:0] {
        BM_FIXED = 2'b00,
        BM_BOTH  = 2'b01,
        BM_LOWER = 2'b10,
        BM_UPPER = 2'b11
    } bank_mode_e;

    // Fine piece answer mode.
    typedef enum logic [1:0] {
        FC_NEVER    = 2'b00,
        FC_WHEN_OUT = 2'b01,
        FC_WHEN_IN  = 2'b10,
        FC_ALWAYS   = 2'b11
    } fine_code_e;

    // Registered decoder outputs.
    typedef struct packed {
        logic sel;
        logic lo_en_n;
        logic hi_en_n;
    } win_out_t;

endpackage

// File: rtl/memwin_half_gate.sv
// Works out which 32K half is live from the bank mode and the occlusion state.
// Assumes two halves; a switchable half dies while the bank is occluded.
module memwin_half_gate
    import memwin_pkg::*;
(
    input  logic [1:0] bank_mode_i,
    input  logic       occluded_i,
    output logic [1:0] half_live_o
);
    localparam int HALVES = 2;

    logic [HALVES-1:0] switchable;

    // Decode which halves follow the bank state.
    always_comb begin
        case (bank_mode_e'(bank_mode_i))
            BM_FIXED: switchable = 2'b00;
            BM_BOTH:  switchable = 2'b11;
            BM_LOWER: switchable = 2'b01;
            BM_UPPER: switchable = 2'b10;
            default:  switchable = 2'b00;
        endcase
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_live_o[h] = !(switchable[h] && occluded_i);
    end

endmodule

// File: rtl/memwin_coarse.sv
// Coarse section decode: one enable per 8K section, gated by its half.
// Assumes the most significant section bit names the 32K half.
module memwin_coarse #(
    parameter int NUM_SECT = 8
) (
    input  logic [$clog2(NUM_SECT)-1:0] sect_idx_i,
    input  logic [NUM_SECT-1:0]         sect_sw_i,
    input  logic [1:0]                  half_live_i,
    output logic                        coarse_hit_o,
    output logic                        in_top_o
);
    localparam int SECT_BITS = $clog2(NUM_SECT);
    localparam logic [SECT_BITS-1:0] TOP_SECT = SECT_BITS'(NUM_SECT - 1);

    logic [NUM_SECT-1:0] sect_hit;

    for (genvar k = 0; k < NUM_SECT; k++) begin : g_sect
        assign sect_hit[k] = sect_sw_i[k] && half_live_i[k / (NUM_SECT / 2)];
    end

    assign coarse_hit_o = sect_hit[sect_idx_i];
    assign in_top_o     = (sect_idx_i == TOP_SECT);

endmodule

// File: rtl/memwin_fine.sv
// Fine decode of the top section: each 2K piece answers per its 2-bit code.
// Assumes an all-zero code set means the coarse path owns the top section.
module memwin_fine
    import memwin_pkg::*;
#(
    parameter int FINE_PIECES = 4
) (
    input  logic [$clog2(FINE_PIECES)-1:0] piece_idx_i,
    input  logic [2*FINE_PIECES-1:0]       fine_sw_i,
    input  logic                           occluded_i,
    output logic                           fine_active_o,
    output logic                           fine_hit_o
);
    logic [FINE_PIECES-1:0] piece_hit;

    for (genvar p = 0; p < FINE_PIECES; p++) begin : g_piece
        // Resolve one piece's code against the bank state.
        always_comb begin
            case (fine_code_e'(fine_sw_i[2*p +: 2]))
                FC_NEVER:    piece_hit[p] = 1'b0;
                FC_WHEN_OUT: piece_hit[p] = occluded_i;
                FC_WHEN_IN:  piece_hit[p] = !occluded_i;
                FC_ALWAYS:   piece_hit[p] = 1'b1;
                default:     piece_hit[p] = 1'b0;
            endcase
        end
    end

    assign fine_active_o = |fine_sw_i;
    assign fine_hit_o    = piece_hit[piece_idx_i];

endmodule

// File: rtl/memwin_quadrant.sv
// Quadrant presence: a part-populated card sits low, or high when remapped.
// Assumes four 16K quadrants and CARD_QUARTERS between 1 and 4.
module memwin_quadrant #(
    parameter int CARD_QUARTERS = 3
) (
    input  logic [1:0] quad_i,
    input  logic       remap_i,
    output logic       present_o
);
    localparam int QUADS = 4;

    logic [QUADS-1:0] mask_low;
    logic [QUADS-1:0] mask_high;

    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        assign mask_low[q]  = (q < CARD_QUARTERS);
        assign mask_high[q] = (q >= QUADS - CARD_QUARTERS);
    end

    assign present_o = remap_i ? mask_high[quad_i] : mask_low[quad_i];

endmodule

// File: rtl/memwin_decode.sv
// Top of the memory window decoder: combines coarse, fine, half and quadrant
// decode and registers the select and half enables.
// Assumes addr_hi_i carries A15..A11 and the bus qualifiers are stable per cycle.
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int NUM_SECT      = 8,
    parameter int FINE_PIECES   = 4,
    parameter int CARD_QUARTERS = 3
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [$clog2(NUM_SECT)+$clog2(FINE_PIECES)-1:0] addr_hi_i,
    input  logic                                       mem_cycle_i,
    input  logic                                       refresh_i,
    input  logic                                       occluded_i,
    input  logic [NUM_SECT-1:0]                        sect_sw_i,
    input  logic [2*FINE_PIECES-1:0]                   fine_sw_i,
    input  logic [1:0]                                 bank_mode_i,
    input  logic                                       remap_i,
    output logic                                       sel_o,
    output logic                                       lo_en_n_o,
    output logic                                       hi_en_n_o
);
    localparam int SECT_BITS  = $clog2(NUM_SECT);
    localparam int PIECE_BITS = $clog2(FINE_PIECES);
    localparam int TAG_W      = SECT_BITS + PIECE_BITS;

    logic [SECT_BITS-1:0]  sect_idx;
    logic [PIECE_BITS-1:0] piece_idx;
    logic [1:0]            half_live;
    logic                  coarse_hit, in_top;
    logic                  fine_active, fine_hit;
    logic                  present;
    logic                  hit;
    win_out_t              nxt, cur;

    assign sect_idx  = addr_hi_i[TAG_W-1 -: SECT_BITS];
    assign piece_idx = addr_hi_i[PIECE_BITS-1:0];

    memwin_half_gate u_gate (
        .bank_mode_i (bank_mode_i),
        .occluded_i  (occluded_i),
        .half_live_o (half_live)
    );

    memwin_coarse #(.NUM_SECT(NUM_SECT)) u_coarse (
        .sect_idx_i   (sect_idx),
        .sect_sw_i    (sect_sw_i),
        .half_live_i  (half_live),
        .coarse_hit_o (coarse_hit),
        .in_top_o     (in_top)
    );

    memwin_fine #(.FINE_PIECES(FINE_PIECES)) u_fine (
        .piece_idx_i   (piece_idx),
        .fine_sw_i     (fine_sw_i),
        .occluded_i    (occluded_i),
        .fine_active_o (fine_active),
        .fine_hit_o    (fine_hit)
    );

    memwin_quadrant #(.CARD_QUARTERS(CARD_QUARTERS)) u_quad (
        .quad_i    (addr_hi_i[TAG_W-1 -: 2]),
        .remap_i   (remap_i),
        .present_o (present)
    );

    // Pick the fine or coarse answer and qualify it with the bus cycle.
    always_comb begin
        hit         = (in_top && fine_active) ? fine_hit : coarse_hit;
        nxt.sel     = mem_cycle_i && !refresh_i && present && hit;
        nxt.lo_en_n = !half_live[0];
        nxt.hi_en_n = !half_live[1];
    end

    // Register the outputs; reset closes the card.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '{sel: 1'b0, lo_en_n: 1'b1, hi_en_n: 1'b1};
        end else begin
            cur <= nxt;
        end
    end

    assign sel_o     = cur.sel;
    assign lo_en_n_o = cur.lo_en_n;
    assign hi_en_n_o = cur.hi_en_n;

endmodule

// File: rtl/memwin_decode_chk.sv
// Property checker for memwin_decode, attached by bind.
// Assumes the default geometry: five address tag bits, eight fine bits.
module memwin_decode_chk #(
    parameter int CARD_QUARTERS = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] addr_hi_i,
    input logic       mem_cycle_i,
    input logic       refresh_i,
    input logic       occluded_i,
    input logic [7:0] sect_sw_i,
    input logic [7:0] fine_sw_i,
    input logic [1:0] bank_mode_i,
    input logic       remap_i,
    input logic       sel_o,
    input logic       lo_en_n_o,
    input logic       hi_en_n_o
);
    // No select unless a memory cycle without refresh.
    assert_bus_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cycle_i || refresh_i) |=> !sel_o);

    // Coarse section closed outside fine mode gives no select.
    assert_coarse_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sect_sw_i[addr_hi_i[4:2]] && !(addr_hi_i[4:2] == 3'd7 && fine_sw_i != 8'd0)) |=> !sel_o);

    // A fine piece coded 00 never answers, even with the coarse top bit set.
    assert_fine_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hi_i[4:2] == 3'd7 && fine_sw_i != 8'd0
         && fine_sw_i[{addr_hi_i[1:0], 1'b0} +: 2] == 2'b00) |=> !sel_o);

    // Fixed mode keeps both halves enabled.
    assert_fixed_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_mode_i == 2'b00) |=> (!lo_en_n_o && !hi_en_n_o));

    // Without occlusion both halves are enabled.
    assert_not_occluded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !occluded_i |=> (!lo_en_n_o && !hi_en_n_o));

    // Both-switchable mode with occlusion closes both halves.
    assert_both_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occluded_i && bank_mode_i == 2'b01) |=> (lo_en_n_o && hi_en_n_o));

    // The unpopulated quadrant never answers.
    assert_quadrant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (CARD_QUARTERS == 3 && ((remap_i && addr_hi_i[4:3] == 2'd0)
                            || (!remap_i && addr_hi_i[4:3] == 2'd3))) |=> !sel_o);

    // Reset drives the closed state.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!sel_o && lo_en_n_o && hi_en_n_o));

endmodule

bind memwin_decode memwin_decode_chk #(.CARD_QUARTERS(CARD_QUARTERS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_hi_i   (addr_hi_i),
    .mem_cycle_i (mem_cycle_i),
    .refresh_i   (refresh_i),
    .occluded_i  (occluded_i),
    .sect_sw_i   (sect_sw_i),
    .fine_sw_i   (fine_sw_i),
    .bank_mode_i (bank_mode_i),
    .remap_i     (remap_i),
    .sel_o       (sel_o),
    .lo_en_n_o   (lo_en_n_o),
    .hi_en_n_o   (hi_en_n_o)
);

// File: tb/memwin_decode_tb_top.sv
// Self-checking bench for memwin_decode: directed corners plus seeded random.
module memwin_decode_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] addr;
    logic       mem, rfsh, occ, remap;
    logic [7:0] sect_sw, fine_sw;
    logic [1:0] mode;
    logic       sel, lo_n, hi_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    memwin_decode dut_i (
        .clk (clk), .rst_n (rst_n), .addr_hi_i (addr),
        .mem_cycle_i (mem), .refresh_i (rfsh), .occluded_i (occ),
        .sect_sw_i (sect_sw), .fine_sw_i (fine_sw), .bank_mode_i (mode),
        .remap_i (remap), .sel_o (sel), .lo_en_n_o (lo_n), .hi_en_n_o (hi_n)
    );

    // Expected {sel, lo_en_n, hi_en_n} from the requirements (3 quarters populated).
    function automatic logic [2:0] model(logic [4:0] a, logic m, logic r, logic o,
                                         logic [7:0] ss, logic [7:0] fs,
                                         logic [1:0] bm, logic rm);
        logic sw_lo, sw_hi, ln, hn, present, h;
        logic [1:0] code;
        sw_lo   = (bm == 2'b01) || (bm == 2'b10);
        sw_hi   = (bm == 2'b01) || (bm == 2'b11);
        ln      = sw_lo && o;
        hn      = sw_hi && o;
        present = rm ? (a[4:3] != 2'd0) : (a[4:3] != 2'd3);
        if (a[4:2] == 3'd7 && fs != 8'd0) begin
            code = fs[a[1:0]*2 +: 2];
            h = (code == 2'b11) || (code == 2'b01 && o) || (code == 2'b10 && !o);
        end else begin
            h = ss[a[4:2]] && !(a[4] ? hn : ln);
        end
        return {m && !r && present && h, ln, hn};
    endfunction

    task automatic check(string req, logic [2:0] exp_v);
        n_tests++;
        if ({sel, lo_n, hi_n} !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got {sel,lo_n,hi_n}=%b expected %b (addr=%h fine=%h sect=%h mode=%b occ=%b remap=%b)",
                     req, {sel, lo_n, hi_n}, exp_v, addr, fine_sw, sect_sw, mode, occ, remap);
        end
    endtask

    // Drive one set of inputs, wait for the registering edge, then compare.
    task automatic apply(string req, logic [4:0] a, logic m, logic r, logic o,
                         logic [7:0] ss, logic [7:0] fs, logic [1:0] bm, logic rm);
        addr = a; mem = m; rfsh = r; occ = o;
        sect_sw = ss; fine_sw = fs; mode = bm; remap = rm;
        @(posedge clk); #1;
        check(req, model(a, m, r, o, ss, fs, bm, rm));
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        addr = 5'd0; mem = 1'b1; rfsh = 1'b0; occ = 1'b0;
        sect_sw = 8'hFF; fine_sw = 8'h00; mode = 2'b00; remap = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 3'b011);
        rst_n = 1'b1;

        // R3: coarse section enabled / disabled
        apply("R3 coarse on",  5'b010_00, 1, 0, 0, 8'h04, 8'h00, 2'b00, 0);
        apply("R3 coarse off", 5'b011_00, 1, 0, 0, 8'h04, 8'h00, 2'b00, 0);
        // R2: output follows the most recent inputs, one cycle later
        apply("R2 follow",     5'b000_00, 1, 0, 0, 8'h01, 8'h00, 2'b00, 0);
        // R4: fine precedence over coarse top bit, E800 hole (piece 1 code 00)
        apply("R4 hole E800",  5'b111_01, 1, 0, 0, 8'h80, 8'hF3, 2'b00, 1);
        apply("R4 fine on E000", 5'b111_00, 1, 0, 0, 8'h00, 8'hF3, 2'b00, 1);
        // R5: each code under both bank states
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 2; o++) begin
                apply("R5 fine code", 5'b111_10, 1, 0, 1'(o), 8'h00,
                      8'(c << 4) | 8'h01, 2'b01, 1);
            end
        end
        // R6: always-on piece while occluded in every bank mode
        for (int bm = 0; bm < 4; bm++) begin
            apply("R6 fine ignores gating", 5'b111_11, 1, 0, 1, 8'h00, 8'hC0, 2'(bm), 1);
        end
        // R7, R8: every mode with occlusion, in each half
        for (int bm = 0; bm < 4; bm++) begin
            apply("R7 lower half gating", 5'b001_00, 1, 0, 1, 8'hFF, 8'h00, 2'(bm), 0);
            apply("R8 upper half gating", 5'b101_00, 1, 0, 1, 8'hFF, 8'h00, 2'(bm), 0);
        end
        // R9: quadrant window with and without remap
        apply("R9 low quad no remap",  5'b000_00, 1, 0, 0, 8'hFF, 8'h00, 2'b00, 0);
        apply("R9 low quad remap",     5'b000_00, 1, 0, 0, 8'hFF, 8'h00, 2'b00, 1);
        apply("R9 top quad no remap",  5'b110_00, 1, 0, 0, 8'hFF, 8'h00, 2'b00, 0);
        apply("R9 top quad remap",     5'b110_00, 1, 0, 0, 8'hFF, 8'h00, 2'b00, 1);
        // R10: refresh and non-memory cycles
        apply("R10 refresh", 5'b010_00, 1, 1, 0, 8'hFF, 8'h00, 2'b00, 0);
        apply("R10 no mem",  5'b010_00, 0, 0, 0, 8'hFF, 8'h00, 2'b00, 0);

        // Seeded random traffic across all requirements
        for (int i = 0; i < 2000; i++) begin
            apply("R3-R10 random mix",
                  5'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 5) == 0),
                  1'($urandom), 8'($urandom), ($urandom_range(0, 1) != 0) ? 8'($urandom) : 8'h00,
                  2'($urandom), 1'($urandom));
        end

        // R1: reset mid-run closes the card again
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 reset again", 3'b011);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule